// File: doc/BRIEF.md
# Memory-Mapped Data-Port Decoder with Interrupt Latch

This block sits between the data port of a small 32-bit processor and the resources that port reaches. Each cycle it decodes the 16-bit data address together with the write strobe. It then steers the access to one of four places: the external data RAM, an internal peripheral register file, a UART transmit port, or an interrupt-vector register. It returns read data one cycle after the access. The RAM itself sits outside this block. The block drives the RAM's word address, write enable and write data, and it takes the RAM's registered read data back in.

The address map is fixed:
- Addresses 0x0000 to 0x7FFF belong to the RAM window. Only 16 KB of RAM is fitted, so bit 14 of the address is dropped.
- Addresses 0x8000 to 0x8FFF form a peripheral window of 1024 words, indexed by address bits [11:2].
- Addresses 0x9000 and above are unmapped.

Two single addresses inside the RAM window act as control ports:
- A write to 0x7FFF issues a one-cycle transmit request that carries the low byte of the write data.
- A write to 0x7FF8 loads the interrupt-vector register, which holds the address the processor jumps to when an interrupt is taken.

The block also holds one interrupt request flag. A one-clock receive pulse sets it, and a one-clock acknowledge pulse clears it. The receive path is the only interrupt source.

All pins are plain control and data signals. There is no handshake, and every access completes in the cycle it is presented.

Top module: `mmio_decoder`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, `irq_vector` is 0, `tx_req` is 0 and `dp_rdata` is 0.
- R2: A write to an address from 0x0000 to 0x7FFF, other than the two control addresses, does the following in the same cycle:
  - it raises `ram_we`;
  - it drives `ram_word_addr` with address bits [13:2], so bit 14 has no effect;
  - it drives `ram_wdata` with the write data.
- R3: In the cycle after any access to an address from 0x0000 to 0x7FFF, `dp_rdata` equals `ram_rdata`.
- R4: A write to an address from 0x8000 to 0x8FFF stores the word at index bits [11:2] of the register file. A later access to that address returns the word on `dp_rdata` one cycle after the access.
- R5: A write to an address of 0x9000 or above changes nothing:
  - `ram_we` stays 0;
  - the register-file word with the same index bits keeps its value.

  One cycle after any access to such an address, `dp_rdata` is 0.
- R6: A write to 0x7FFF makes `tx_req` high for exactly the following cycle, with `tx_byte` equal to bits [7:0] of the write data.
- R7: A write to 0x7FF8 loads the full write word into `irq_vector`, visible from the following cycle.
- R8: A write to 0x7FFF or to 0x7FF8 does not raise `ram_we`.
- R9: A `rx_pulse` without `irq_ack` sets `irq_req` from the next cycle. The flag then stays at 1 until an acknowledge arrives.
- R10: An `irq_ack` clears `irq_req` in the next cycle. This also holds when `rx_pulse` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dp_addr | input | 16 | Data-port byte address |
| dp_wdata | input | 32 | Data-port write data |
| dp_we | input | 1 | Data-port write strobe |
| dp_rdata | output | 32 | Read data, one cycle after the access |
| ram_word_addr | output | 12 | RAM word index (address bits [13:2]) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | Registered RAM read data |
| tx_req | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit |
| rx_pulse | input | 1 | One-clock pulse for a received byte |
| irq_ack | input | 1 | One-clock interrupt acknowledge |
| irq_req | output | 1 | Interrupt request flag |
| irq_vector | output | 32 | Interrupt service address |

## Verification
The properties assume the following about the inputs:
- `rx_pulse` and `irq_ack` are single-cycle pulses;
- the RAM behind the port returns its registered word in the cycle after the address is presented;
- `dp_addr` is stable at each rising edge.

The stimulus drives every input on the falling edge and lowers the write strobe between writes. It never issues two transmit writes back to back, so each `tx_req` pulse can be attributed to one write. A RAM model inside the bench gives the one-cycle read timing. Expected values come from a separate shadow copy kept by the driver tasks.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PERI = 2'd2
  } tgt_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PERI_BASE = 16'h8000,
  parameter logic [15:0] PERI_END  = 16'h8FFF,
  parameter logic [15:0] TX_ADDR   = 16'h7FFF,
  parameter logic [15:0] VEC_ADDR  = 16'h7FF8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output tgt_e              tgt,
  output logic              ram_wr,
  output logic              peri_wr,
  output logic              tx_wr,
  output logic              vec_wr
);
  logic is_tx, is_vec;

  always_comb begin
    if (addr < PERI_BASE)       tgt = TGT_RAM;
    else if (addr <= PERI_END)  tgt = TGT_PERI;
    else                        tgt = TGT_NONE;
  end

  assign is_tx   = (addr == TX_ADDR);
  assign is_vec  = (addr == VEC_ADDR);
  assign tx_wr   = we && is_tx;
  assign vec_wr  = we && is_vec;
  assign ram_wr  = we && (tgt == TGT_RAM) && !is_tx && !is_vec;
  assign peri_wr = we && (tgt == TGT_PERI);
endmodule

// File: rtl/mmio_regfile.sv
module mmio_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= wdata;
    rdata <= mem[idx];
  end
endmodule

// File: rtl/mmio_irq_latch.sv
module mmio_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_pulse,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (clr_pulse) flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
  end
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
  import mmio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RF_IDX_W  = 10,
  parameter int RAM_IDX_W = 12,
  parameter int BYTE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    dp_addr,
  input  logic [DATA_W-1:0]    dp_wdata,
  input  logic                 dp_we,
  output logic [DATA_W-1:0]    dp_rdata,
  output logic [RAM_IDX_W-1:0] ram_word_addr,
  output logic                 ram_we,
  output logic [DATA_W-1:0]    ram_wdata,
  input  logic [DATA_W-1:0]    ram_rdata,
  output logic                 tx_req,
  output logic [BYTE_W-1:0]    tx_byte,
  input  logic                 rx_pulse,
  input  logic                 irq_ack,
  output logic                 irq_req,
  output logic [DATA_W-1:0]    irq_vector
);
  localparam int WORD_LSB = 2;

  tgt_e              tgt, tgt_q;
  logic              peri_wr, tx_wr, vec_wr;
  logic [DATA_W-1:0] rf_rdata;

  mmio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(dp_addr), .we(dp_we), .tgt(tgt), .ram_wr(ram_we),
    .peri_wr(peri_wr), .tx_wr(tx_wr), .vec_wr(vec_wr)
  );

  mmio_regfile #(.DATA_W(DATA_W), .IDX_W(RF_IDX_W)) u_rf (
    .clk(clk), .idx(dp_addr[WORD_LSB +: RF_IDX_W]), .wr(peri_wr),
    .wdata(dp_wdata), .rdata(rf_rdata)
  );

  mmio_irq_latch u_irq (
    .clk(clk), .rst(rst), .set_pulse(rx_pulse), .clr_pulse(irq_ack), .flag(irq_req)
  );

  assign ram_word_addr = dp_addr[WORD_LSB +: RAM_IDX_W];
  assign ram_wdata     = dp_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q      <= TGT_NONE;
      tx_req     <= 1'b0;
      tx_byte    <= '0;
      irq_vector <= '0;
    end else begin
      tgt_q  <= tgt;
      tx_req <= tx_wr;
      if (tx_wr)  tx_byte    <= dp_wdata[BYTE_W-1:0];
      if (vec_wr) irq_vector <= dp_wdata;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_RAM:  dp_rdata = ram_rdata;
      TGT_PERI: dp_rdata = rf_rdata;
      default:  dp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmio_decoder_chk.sv
module mmio_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] dp_addr,
  input logic [31:0] dp_wdata,
  input logic        dp_we,
  input logic [31:0] dp_rdata,
  input logic        ram_we,
  input logic [31:0] ram_rdata,
  input logic        tx_req,
  input logic [7:0]  tx_byte,
  input logic        rx_pulse,
  input logic        irq_ack,
  input logic        irq_req,
  input logic [31:0] irq_vector
);
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    (dp_we && dp_addr == 16'h7FFF) |=> (tx_req && tx_byte == $past(dp_wdata[7:0]))); // R6
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(dp_we && dp_addr == 16'h7FFF) |=> !tx_req); // R6
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (dp_we && dp_addr == 16'h7FF8) |=> (irq_vector == $past(dp_wdata))); // R7
  AST_CTL_NO_RAM: assert property (@(posedge clk) disable iff (rst)
    (dp_we && (dp_addr == 16'h7FFF || dp_addr == 16'h7FF8)) |-> !ram_we); // R8
  AST_UNMAPPED_NO_RAM: assert property (@(posedge clk) disable iff (rst)
    (dp_addr >= 16'h9000) |-> !ram_we); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dp_addr >= 16'h9000) |=> (dp_rdata == 32'd0)); // R5
  AST_RAM_RDATA: assert property (@(posedge clk) disable iff (rst)
    (dp_addr < 16'h8000) |=> (dp_rdata == ram_rdata)); // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_pulse && !irq_ack) |=> irq_req); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req); // R10
endmodule

bind mmio_decoder mmio_decoder_chk u_chk (
  .clk(clk), .rst(rst), .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dp_we(dp_we),
  .dp_rdata(dp_rdata), .ram_we(ram_we), .ram_rdata(ram_rdata), .tx_req(tx_req),
  .tx_byte(tx_byte), .rx_pulse(rx_pulse), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_vector(irq_vector)
);

// File: tb/mmio_decoder_bench.sv
module mmio_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] dp_addr;
  logic [31:0] dp_wdata;
  logic        dp_we;
  logic [31:0] dp_rdata;
  logic [11:0] ram_word_addr;
  logic        ram_we;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;
  logic        tx_req;
  logic [7:0]  tx_byte;
  logic        rx_pulse;
  logic        irq_ack;
  logic        irq_req;
  logic [31:0] irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mmio_decoder u_mmio_decoder (
    .clk(clk), .rst(rst), .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dp_we(dp_we),
    .dp_rdata(dp_rdata), .ram_word_addr(ram_word_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .tx_req(tx_req), .tx_byte(tx_byte),
    .rx_pulse(rx_pulse), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // RAM model with one-cycle registered read
  logic [31:0] ram_mem [4096];
  always_ff @(posedge clk) begin
    if (ram_we) ram_mem[ram_word_addr] <= ram_wdata;
    ram_rdata <= ram_mem[ram_word_addr];
  end

  logic [31:0] ram_shadow [4096];
  logic [31:0] rf_shadow  [1024];

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t exp_q [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read result after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, dp_rdata, e.data);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit exp_ram_we);
    @(negedge clk);
    dp_addr = a; dp_wdata = d; dp_we = 1'b1;
    #1;
    if (!exp_ram_we || a >= 16'h8000) check("R8/R5 ram_we", {31'd0, ram_we}, {31'd0, exp_ram_we});
    if (exp_ram_we) begin
      check("R2 ram_word_addr", {20'd0, ram_word_addr}, {20'd0, a[13:2]});
      ram_shadow[a[13:2]] = d;
    end
    if (a >= 16'h8000 && a <= 16'h8FFF) rf_shadow[a[11:2]] = d;
    @(negedge clk);
    dp_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    dp_addr = a; dp_we = 1'b0;
    exp_q.push_back('{exp, tag});
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; dp_addr = 16'h9000; dp_wdata = '0; dp_we = 1'b0;
    rx_pulse = 1'b0; irq_ack = 1'b0;
    for (int i = 0; i < 4096; i++) begin ram_mem[i] = 32'h0; ram_shadow[i] = 32'h0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 irq_req", {31'd0, irq_req}, 32'd0);
    check("R1 irq_vector", irq_vector, 32'd0);
    check("R1 tx_req", {31'd0, tx_req}, 32'd0);
    check("R1 dp_rdata", dp_rdata, 32'd0);

    // R4: every peripheral word, distinct pattern
    for (int i = 0; i < 1024; i++)
      wr(16'h8000 + 16'(i * 4), {16'(i), 16'(i)} ^ 32'hA5A5_0000, 1'b0);
    for (int i = 0; i < 1024; i++)
      rd(16'h8000 + 16'(i * 4), {16'(i), 16'(i)} ^ 32'hA5A5_0000, "R4 peri readback");
    drain();

    // R5: unmapped write aliases index 1 but must not store; read returns 0
    wr(16'h9004, 32'hDEAD_BEEF, 1'b0);
    rd(16'h8004, rf_shadow[1], "R5 peri unchanged");
    rd(16'h9004, 32'd0, "R5 unmapped read zero");
    rd(16'hFFFC, 32'd0, "R5 top unmapped read zero");
    drain();

    // R2/R3: RAM window, bit 14 ignored
    wr(16'h0010, 32'h1111_2222, 1'b1);
    wr(16'h4020, 32'h3333_4444, 1'b1);
    rd(16'h0010, 32'h1111_2222, "R3 ram read");
    rd(16'h0020, 32'h3333_4444, "R2 bit14 alias read");
    rd(16'h4010, 32'h1111_2222, "R2 bit14 alias read hi");
    drain();

    // R6/R8: transmit port
    wr(16'h7FFC, 32'h0BAD_F00D, 1'b1);
    @(negedge clk); dp_addr = 16'h7FFF; dp_wdata = 32'h1234_56C3; dp_we = 1'b1;
    #1 check("R8 tx no ram_we", {31'd0, ram_we}, 32'd0);
    @(negedge clk); dp_we = 1'b0; dp_addr = 16'h9000;
    check("R6 tx_req high", {31'd0, tx_req}, 32'd1);
    check("R6 tx_byte", {24'd0, tx_byte}, 32'h0000_00C3);
    @(negedge clk);
    check("R6 tx_req one cycle", {31'd0, tx_req}, 32'd0);
    rd(16'h7FFC, 32'h0BAD_F00D, "R8 ram neighbor intact");
    drain();

    // R7/R8: vector register
    @(negedge clk); dp_addr = 16'h7FF8; dp_wdata = 32'h0000_0ABC; dp_we = 1'b1;
    #1 check("R8 vec no ram_we", {31'd0, ram_we}, 32'd0);
    @(negedge clk); dp_we = 1'b0; dp_addr = 16'h9000;
    check("R7 irq_vector", irq_vector, 32'h0000_0ABC);
    check("R6 no tx on vec write", {31'd0, tx_req}, 32'd0);
    rd(16'h7FF8, 32'd0, "R8 ram at vec addr unwritten");
    drain();

    // R9/R10: interrupt latch
    @(negedge clk); rx_pulse = 1'b1;
    @(negedge clk); rx_pulse = 1'b0;
    check("R9 irq set", {31'd0, irq_req}, 32'd1);
    repeat (3) @(negedge clk);
    check("R9 irq held", {31'd0, irq_req}, 32'd1);
    irq_ack = 1'b1; rx_pulse = 1'b1;
    @(negedge clk); irq_ack = 1'b0; rx_pulse = 1'b0;
    check("R10 ack wins", {31'd0, irq_req}, 32'd0);
    @(negedge clk);
    check("R10 stays clear", {31'd0, irq_req}, 32'd0);
    rx_pulse = 1'b1;
    @(negedge clk); rx_pulse = 1'b0;
    check("R9 set again", {31'd0, irq_req}, 32'd1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 ack clears", {31'd0, irq_req}, 32'd0);

    // R1: reset clears vector and flag
    rx_pulse = 1'b1;
    @(negedge clk); rx_pulse = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 vector after reset", irq_vector, 32'd0);
    check("R1 irq after reset", {31'd0, irq_req}, 32'd0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule